// File: doc/BRIEF.md
# Bus target termination generator

This block is the termination logic of a target on a PCI-style parallel bus with active-low control lines. It watches the initiator's FRAME# and IRDY# lines. When FRAME# falls while the target is idle, the block claims the cycle by driving DEVSEL#. From then on it drives TRDY# whenever the local side reports that a data word is ready. It counts each word that actually moves, which is a clock on which IRDY# and TRDY# are both low. Address decoding and the data path stay outside the block: every address phase is claimed.

The local side can ask the target to suspend the transaction with a stop strobe or a retry strobe. The block answers by asserting STOP#, and the TRDY# level that goes with STOP# selects the outcome. With TRDY# asserted alongside STOP#, one last word may still move. With TRDY# deasserted, nothing more moves. If no word has moved at all, the initiator reads the termination as a retry. STOP# stays asserted until the initiator has let go of the bus. A two-bit code reports how the last transaction ended, and the code and the word count both hold until the next address phase.

Top module: `tt_target_term`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and STOP# are high (deasserted), the word count is 0 and the termination code is 0.
- R2: When FRAME# is sampled low while the target is idle (an address phase), DEVSEL# goes low on the next clock, and on that same clock the word count returns to 0 and the termination code returns to 0.
- R3: While the cycle is claimed and no stop has been requested, TRDY# goes low on the clock after data_rdy is sampled high. Once low, TRDY# stays low until a transfer occurs. TRDY# is not reasserted after a transfer that took place with FRAME# high.
- R4: The word count increments by one on each clock where IRDY# and TRDY# are both sampled low. With saturation enabled, the count stops at 2^CNT_W-1.
- R5: A stop_req or retry_req sampled high during a claimed cycle drives STOP# low on the next clock. STOP# then stays low until the clock after FRAME# and IRDY# are both sampled high.
- R6: When stop_req is sampled high together with data_rdy and without retry_req, STOP# and TRDY# go low together (disconnect with data) and the code becomes 1.
- R7: When the stop request cannot carry data (retry_req high, or data_rdy low), and at least one word has moved (counting a transfer in the request clock itself), TRDY# is deasserted with STOP# and the code becomes 2 (disconnect without data).
- R8: A stop request that cannot carry data, made while no word has moved, deasserts TRDY# and sets the code to 3 (retry).
- R9: Once STOP# is low, TRDY# goes high on the clock after a transfer, or at once if TRDY# was high alongside STOP#, and it stays high for the rest of the transaction.
- R10: On the clock after FRAME# and IRDY# are both sampled high during a claimed cycle, DEVSEL#, TRDY# and STOP# all go high. The code and the word count keep their values.
- R11: While the target is idle, data_rdy, stop_req and retry_req have no effect: TRDY# and STOP# stay high.
- R12: A transaction that ends without any stop request leaves the code at 0 (normal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Initiator FRAME#, active low |
| irdy_n | input | 1 | Initiator IRDY#, active low |
| data_rdy | input | 1 | Local side has a word ready for this clock |
| stop_req | input | 1 | Local request to suspend the transaction |
| retry_req | input | 1 | Local request to suspend with no further data |
| devsel_n | output | 1 | DEVSEL#, active low |
| trdy_n | output | 1 | TRDY#, active low |
| stop_n | output | 1 | STOP#, active low |
| word_cnt | output | CNT_W | Words transferred in the current or last transaction |
| term_code | output | 2 | 0 normal, 1 disconnect with data, 2 disconnect without data, 3 retry |

## Verification
A stop request can land on the same clock as the transfer of the first word. Whether that request yields a retry or a disconnect without data then depends on the transfer that is completing in that very cycle. The bench builds this on purpose: it raises TRDY#, then drives IRDY# low together with retry_req. It expects code 2 with a word count of 1, where the same request one clock earlier gives code 3. Random traffic then mixes stop strobes, ready strobes and IRDY# waits, and every cycle is compared against a bench model of the requirements.

// File: rtl/tt_pkg.sv
package tt_pkg;
   typedef enum logic [1:0] {
      TT_NORMAL      = 2'd0,
      TT_DISC_DATA   = 2'd1,
      TT_DISC_NODATA = 2'd2,
      TT_RETRY       = 2'd3
   } term_e;
endpackage

// File: rtl/tt_phase.sv
module tt_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic irdy_n,
   output logic active,
   output logic addr_phase,
   output logic bus_end
);
   // claim every address phase seen while idle
   assign addr_phase = !active && !frame_n;
   // both initiator lines released during a claimed cycle
   assign bus_end    = active && frame_n && irdy_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          active <= 1'b0;
      else if (addr_phase) active <= 1'b1;
      else if (bus_end)    active <= 1'b0;
   end

   // R2: an address phase always leads to a claimed cycle
   assert_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_phase |=> active);
endmodule

// File: rtl/tt_word_cnt.sv
module tt_word_cnt #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_next;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            cnt_next = cnt;
            if (clear)                     cnt_next = '0;
            else if (inc && cnt != CNT_MAX) cnt_next = cnt + 1'b1;
         end
         // R4: a saturated count holds while transfers continue
         assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == CNT_MAX) && !clear |=> cnt == CNT_MAX);
      end else begin : g_wrap
         always_comb begin
            cnt_next = cnt;
            if (clear)    cnt_next = '0;
            else if (inc) cnt_next = cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_next;
   end

   assign zero = (cnt == '0);

   // R4: no transfer and no clear leaves the count untouched
   assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clear && !inc |=> $stable(cnt));
endmodule

// File: rtl/tt_stop_ctl.sv
module tt_stop_ctl
   import tt_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  active,
   input  logic  addr_phase,
   input  logic  bus_end,
   input  logic  frame_n,
   input  logic  xfer,
   input  logic  cnt_zero,
   input  logic  data_rdy,
   input  logic  stop_req,
   input  logic  retry_req,
   output logic  trdy_q,
   output logic  stop_q,
   output term_e code_q
);
   logic  trdy_d, stop_d;
   term_e code_d;
   logic  none_moved;

   // no word has moved, counting a transfer completing right now
   assign none_moved = cnt_zero && !xfer;

   always_comb begin
      trdy_d = 1'b0;
      stop_d = 1'b0;
      code_d = code_q;
      if (addr_phase) begin
         code_d = TT_NORMAL;
      end else if (!active || bus_end) begin
         trdy_d = 1'b0;
      end else if (stop_q) begin
         stop_d = 1'b1;
         trdy_d = trdy_q && !xfer;
      end else if (stop_req || retry_req) begin
         stop_d = 1'b1;
         if (stop_req && !retry_req && data_rdy) begin
            trdy_d = 1'b1;
            code_d = TT_DISC_DATA;
         end else begin
            trdy_d = 1'b0;
            code_d = none_moved ? TT_RETRY : TT_DISC_NODATA;
         end
      end else begin
         trdy_d = (data_rdy || (trdy_q && !xfer)) && !(frame_n && xfer);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trdy_q <= 1'b0;
         stop_q <= 1'b0;
         code_q <= TT_NORMAL;
      end else begin
         trdy_q <= trdy_d;
         stop_q <= stop_d;
         code_q <= code_d;
      end
   end

   // R5: STOP# is held until the bus is released
   assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q && !bus_end |=> stop_q);
   // R9: TRDY# stays off after the last word under STOP#
   assert_trdy_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q && (!trdy_q || xfer) |=> !trdy_q);
   // R6: any STOP# carries a non-normal code
   assert_code_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_q) |-> code_q != TT_NORMAL);
endmodule

// File: rtl/tt_target_term.sv
module tt_target_term #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic             data_rdy,
   input  logic             stop_req,
   input  logic             retry_req,
   output logic             devsel_n,
   output logic             trdy_n,
   output logic             stop_n,
   output logic [CNT_W-1:0] word_cnt,
   output logic [1:0]       term_code
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("tt_target_term: CNT_W must be within 1..32");
      end
   endgenerate

   logic          active, addr_phase, bus_end;
   logic          trdy_q, stop_q, cnt_zero, xfer;
   tt_pkg::term_e code_q;

   assign xfer = !irdy_n && trdy_q;

   tt_phase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_n    (frame_n),
      .irdy_n     (irdy_n),
      .active     (active),
      .addr_phase (addr_phase),
      .bus_end    (bus_end)
   );

   tt_word_cnt #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (addr_phase),
      .inc   (xfer),
      .cnt   (word_cnt),
      .zero  (cnt_zero)
   );

   tt_stop_ctl u_stop (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .addr_phase (addr_phase),
      .bus_end    (bus_end),
      .frame_n    (frame_n),
      .xfer       (xfer),
      .cnt_zero   (cnt_zero),
      .data_rdy   (data_rdy),
      .stop_req   (stop_req),
      .retry_req  (retry_req),
      .trdy_q     (trdy_q),
      .stop_q     (stop_q),
      .code_q     (code_q)
   );

   assign devsel_n  = !active;
   assign trdy_n    = !trdy_q;
   assign stop_n    = !stop_q;
   assign term_code = code_q;

   // R11: an idle target drives neither TRDY# nor STOP#
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !trdy_q && !stop_q);
   // R10: bus release returns all target lines to idle
   assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_end |=> devsel_n && trdy_n && stop_n);
endmodule

// File: tb/sim_tt_target_term.sv
module sim_tt_target_term;
   localparam int W = 3;
   localparam logic [W-1:0] MAXC = {W{1'b1}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic frame_n = 1'b1, irdy_n = 1'b1, data_rdy = 1'b0, stop_req = 1'b0, retry_req = 1'b0;
   logic devsel_n, trdy_n, stop_n;
   logic [W-1:0] word_cnt;
   logic [1:0] term_code;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model state (asserted-high)
   logic m_act = 0, m_trdy = 0, m_stop = 0;
   logic [W-1:0] m_cnt = '0;
   logic [1:0] m_code = 2'd0;

   always #5 clk = ~clk;

   tt_target_term #(.CNT_W(W), .SATURATE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
      .data_rdy(data_rdy), .stop_req(stop_req), .retry_req(retry_req),
      .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
      .word_cnt(word_cnt), .term_code(term_code)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic f, input logic i, input logic d, input logic s, input logic r);
      frame_n = f; irdy_n = i; data_rdy = d; stop_req = s; retry_req = r;
   endtask

   // next-state prediction taken from the requirements
   task automatic predict();
      logic addr, fin, x, n_trdy, n_stop;
      logic [1:0] n_code;
      logic [W-1:0] n_cnt;
      addr = !m_act && !frame_n;
      fin  = m_act && frame_n && irdy_n;
      x    = !irdy_n && m_trdy;
      n_cnt = m_cnt;
      if (addr) n_cnt = '0;
      else if (x && m_cnt != MAXC) n_cnt = m_cnt + 1'b1;
      n_trdy = 0; n_stop = 0; n_code = m_code;
      if (addr) n_code = 2'd0;
      else if (m_act && !fin) begin
         if (m_stop) begin
            n_stop = 1; n_trdy = m_trdy && !x;
         end else if (stop_req || retry_req) begin
            n_stop = 1;
            if (stop_req && !retry_req && data_rdy) begin
               n_trdy = 1; n_code = 2'd1;
            end else
               n_code = (m_cnt == 0 && !x) ? 2'd3 : 2'd2;
         end else
            n_trdy = (data_rdy || (m_trdy && !x)) && !(frame_n && x);
      end
      m_act  = addr ? 1'b1 : (fin ? 1'b0 : m_act);
      m_trdy = n_trdy; m_stop = n_stop; m_cnt = n_cnt; m_code = n_code;
   endtask

   task automatic step();
      predict();
      @(posedge clk);
      @(negedge clk);
      chk("R2", "devsel_n", devsel_n, !m_act);
      chk("R3", "trdy_n", trdy_n, !m_trdy);
      chk("R5", "stop_n", stop_n, !m_stop);
      chk("R4", "word_cnt", word_cnt, m_cnt);
      chk("R6", "term_code", term_code, m_code);
   endtask

   task automatic addr_phase();
      drive(0, 1, 0, 0, 0); step();
      chk("R2", "devsel after address", devsel_n, 0);
      chk("R2", "count cleared", word_cnt, 0);
      chk("R2", "code cleared", term_code, 0);
   endtask

   task automatic release_bus();
      drive(1, 1, 0, 0, 0); step();
      chk("R10", "devsel released", devsel_n, 1);
      chk("R10", "trdy released", trdy_n, 1);
      chk("R10", "stop released", stop_n, 1);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4177));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1", "devsel_n", devsel_n, 1);
      chk("R1", "trdy_n", trdy_n, 1);
      chk("R1", "stop_n", stop_n, 1);
      chk("R1", "word_cnt", word_cnt, 0);
      chk("R1", "term_code", term_code, 0);

      // idle strobes ignored
      drive(1, 1, 1, 1, 1); step(); step();
      chk("R11", "trdy idle", trdy_n, 1);
      chk("R11", "stop idle", stop_n, 1);
      chk("R11", "devsel idle", devsel_n, 1);

      // retry before any data
      addr_phase();
      drive(0, 1, 0, 0, 1); step();
      chk("R8", "stop asserted", stop_n, 0);
      chk("R8", "trdy off", trdy_n, 1);
      chk("R8", "code retry", term_code, 3);
      drive(0, 1, 0, 0, 0); step(); step();
      chk("R5", "stop held", stop_n, 0);
      release_bus();
      chk("R10", "code kept", term_code, 3);

      // disconnect with data
      addr_phase();
      drive(0, 0, 1, 0, 0); step();
      chk("R3", "trdy on ready", trdy_n, 0);
      drive(0, 0, 1, 1, 0); step();
      chk("R6", "stop with trdy", stop_n, 0);
      chk("R6", "trdy with stop", trdy_n, 0);
      chk("R6", "code disc data", term_code, 1);
      drive(1, 0, 0, 0, 0); step();
      chk("R9", "trdy off after word", trdy_n, 1);
      chk("R4", "two words", word_cnt, 2);
      chk("R5", "stop kept", stop_n, 0);
      release_bus();
      chk("R10", "count kept", word_cnt, 2);

      // disconnect without data
      addr_phase();
      drive(0, 0, 1, 0, 0); step();
      drive(0, 0, 0, 0, 0); step();
      drive(0, 1, 0, 1, 0); step();
      chk("R7", "code disc nodata", term_code, 2);
      chk("R7", "trdy off", trdy_n, 1);
      release_bus();

      // retry strobe on the same clock as the first transfer
      addr_phase();
      drive(0, 1, 1, 0, 0); step();
      drive(0, 0, 0, 0, 1); step();
      chk("R7", "same-clock code", term_code, 2);
      chk("R7", "same-clock count", word_cnt, 1);
      chk("R9", "trdy off same-clock", trdy_n, 1);
      release_bus();

      // normal burst with saturation
      addr_phase();
      drive(0, 0, 1, 0, 0);
      for (int k = 0; k < 10; k++) step();
      chk("R4", "count saturated", word_cnt, 7);
      drive(1, 0, 0, 0, 0); step();
      chk("R3", "no trdy after final", trdy_n, 1);
      release_bus();
      chk("R12", "code normal", term_code, 0);

      // random traffic
      for (int k = 0; k < 4000; k++) begin
         drive(($urandom % 8) >= 5, $urandom % 2, $urandom % 2,
               ($urandom % 8) == 0, ($urandom % 16) == 0);
         step();
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule